// File: doc/BRIEF.md
# ADC Result Output Port

This block presents a converter's 16-bit result word to a host, either all at once on a parallel bus or one bit at a time on a serial data line, most significant bit first. Each conversion-done strobe captures the incoming result into a holding word and into a shift register. The format select sets the code: offset binary, or two's complement made by inverting the top bit. The port drives data only while chip select and read are both low.

In serial mode the port runs either as clock master or as clock slave. As master, it divides the system clock to make its own bit clock, sends exactly one word per read, and drives a frame sync for as long as the word is being sent. The sync polarity is selectable. As slave, it shifts on an external bit clock, which chip select gates. The clock-invert input picks which external edge moves the data. If a new conversion completes while a slave read is only partly done, the port drops the rest of the old word, pulses an error flag for one system clock, and restarts from the new word's MSB. The external clock is passed through a synchronizer and its edges are detected in the system clock domain, so it must run well below the system clock.

Top module: `adc_result_port`

## Requirements
- R1: While reset is asserted (rst_n low) and in the cycle after it is released, par_out is 0, sdout is 0, sclk_out is 0, rd_err is 0 and sync_out sits at its inactive level.
- R2: With ser_sel low and both cs_n and rd_n low, par_out equals the formatted word captured by the last done strobe. The word is captured at the clock edge where done is high.
- R3: With twos_sel high when done is sampled, the captured word is the result with bit W-1 inverted. With twos_sel low, the result is captured unchanged.
- R4: Unless cs_n and rd_n are both low, par_out and sdout are 0.
- R5: In master mode (ser_sel high, ext_sel low), a falling edge on the combined read enable starts a transfer of exactly W pulses on sclk_out. Each pulse is DIV clocks high, preceded by DIV clocks low. sdout carries bits W-1 down to 0 in order and is valid while sclk_out is high. sclk_out then returns low.
- R6: In master mode, sync_out is active while a transfer runs and inactive otherwise. It is active high when inv_sync is 0 and active low when inv_sync is 1. Outside master mode it is held at the inactive level.
- R7: In slave mode (ser_sel high, ext_sel high), sdout starts at the MSB and moves to the next bit on each rising edge of sclk_in when inv_sclk is 0, or on each falling edge when inv_sclk is 1.
- R8: In slave mode, sclk_in edges that occur while cs_n is high do not move the shift register.
- R9: In slave mode, a done strobe that arrives after at least one but fewer than W shifting edges since the last capture raises rd_err for exactly one clock. The shift register reloads, so the next read starts at the new word's MSB.
- R10: A done strobe that arrives with no shifting edge since the last capture, or after W or more, leaves rd_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result | input | W | Converter result, offset binary |
| done | input | 1 | Conversion-done strobe, one clock |
| cs_n | input | 1 | Chip select, active low; also gates sclk_in |
| rd_n | input | 1 | Read, active low |
| ser_sel | input | 1 | 1 = serial output, 0 = parallel output |
| ext_sel | input | 1 | 1 = slave (external clock), 0 = master |
| inv_sclk | input | 1 | Slave shifting edge: 0 rising, 1 falling |
| inv_sync | input | 1 | Frame sync polarity: 0 active high, 1 active low |
| twos_sel | input | 1 | 1 = two's complement output |
| sclk_in | input | 1 | External serial clock |
| par_out | output | W | Parallel data bus |
| sdout | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated serial clock in master mode |
| sync_out | output | 1 | Frame sync in master mode |
| rd_err | output | 1 | Incomplete-read error pulse |

## Verification
The bench builds the block with W = 16, the real word width, and DIV = 2. The short divider keeps each master transfer to about 64 clocks, so dozens of random reads in every mode and polarity fit in a short run while the full 16-pulse count is still covered. Directed cases cut a slave read short at 5 bits to raise the error and then read the new word from its MSB. They also toggle the external clock while chip select is high, and send strobes right after a capture and right after a complete read, where no error may appear.

// File: rtl/adc_result_port.sv
module adc_result_port #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] result,
  input  logic         done,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         ser_sel,
  input  logic         ext_sel,
  input  logic         inv_sclk,
  input  logic         inv_sync,
  input  logic         twos_sel,
  input  logic         sclk_in,
  output logic [W-1:0] par_out,
  output logic         sdout,
  output logic         sclk_out,
  output logic         sync_out,
  output logic         rd_err
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(W + 1);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [DW-1:0] DMAX = DW'(DIV - 1);

  logic [W-1:0]  word_q, sh_q, fmt;
  logic [CW-1:0] bcnt, scnt;
  logic [DW-1:0] dcnt;
  logic          active, ph, en_q;
  logic          s1, s2, s3;
  logic          en, master, slave, rise, fall, upd, inprog;

  assign fmt    = twos_sel ? {~result[W-1], result[W-2:0]} : result;
  assign en     = !cs_n && !rd_n;
  assign master = ser_sel && !ext_sel;
  assign slave  = ser_sel && ext_sel;
  assign rise   = s2 && !s3 && !cs_n;
  assign fall   = !s2 && s3 && !cs_n;
  assign upd    = slave && (inv_sclk ? fall : rise);
  assign inprog = (scnt != '0) && (scnt < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sclk_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      sh_q   <= '0;
      bcnt   <= '0;
      scnt   <= '0;
      dcnt   <= '0;
      active <= 1'b0;
      ph     <= 1'b0;
      en_q   <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      en_q   <= en;
      rd_err <= 1'b0;
      if (done) begin
        word_q <= fmt;
        sh_q   <= fmt;
        scnt   <= '0;
        active <= 1'b0;
        ph     <= 1'b0;
        rd_err <= slave && inprog;
      end else begin
        if (!master || !en) begin
          active <= 1'b0;
          ph     <= 1'b0;
        end else if (!active && !en_q) begin
          active <= 1'b1;
          ph     <= 1'b0;
          dcnt   <= '0;
          bcnt   <= '0;
        end else if (active) begin
          if (dcnt == DMAX) begin
            dcnt <= '0;
            ph   <= !ph;
            if (ph) begin
              sh_q <= sh_q << 1;
              bcnt <= bcnt + 1'b1;
              if (bcnt == LAST) active <= 1'b0;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        if (upd) begin
          sh_q <= sh_q << 1;
          if (scnt < FULL) scnt <= scnt + 1'b1;
        end
      end
    end
  end

  assign par_out  = (en && !ser_sel) ? word_q : '0;
  assign sdout    = en && ser_sel && sh_q[W-1];
  assign sclk_out = active && ph;
  assign sync_out = master ? (active ^ inv_sync) : inv_sync;

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(done) && $past(slave));
  // R5
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bcnt < FULL);
  // R5
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) && $past(en && master && !done) |-> bcnt == FULL);
  // R6
  sync_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out |-> sync_out != inv_sync);
  // R10
  slave_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= FULL);
endmodule

// File: tb/tb_adc_result_port.sv
module tb_adc_result_port;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 16;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] result = '0;
  logic done = 0, cs_n = 1, rd_n = 1, ser_sel = 0, ext_sel = 0;
  logic inv_sclk = 0, inv_sync = 0, twos_sel = 0, sclk_in = 0;
  logic [W-1:0] par_out;
  logic sdout, sclk_out, sync_out, rd_err;
  int vectors = 0, miscompares = 0;

  adc_result_port #(.W(W), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .result(result), .done(done), .cs_n(cs_n),
    .rd_n(rd_n), .ser_sel(ser_sel), .ext_sel(ext_sel), .inv_sclk(inv_sclk),
    .inv_sync(inv_sync), .twos_sel(twos_sel), .sclk_in(sclk_in),
    .par_out(par_out), .sdout(sdout), .sclk_out(sclk_out),
    .sync_out(sync_out), .rd_err(rd_err));

  always #10 clk = ~clk;

  function automatic logic [W-1:0] exp_fmt(input logic [W-1:0] r, input logic t);
    return t ? (r ^ (1 << (W - 1))) : r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic ser, input logic ext, input logic is, input logic iy);
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    ser_sel = ser; ext_sel = ext; inv_sclk = is; inv_sync = iy;
    sclk_in = !is;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe(input logic [W-1:0] r, input logic t, input logic exp_err, input string req);
    @(negedge clk);
    result = r; twos_sel = t; done = 1;
    @(negedge clk);
    done = 0;
    chk(req, rd_err, exp_err);
    @(negedge clk);
    chk(req, rd_err, 0);
  endtask

  task automatic master_read(input logic [W-1:0] exp);
    logic [W-1:0] bits = '0;
    int pulses = 0, syncbad = 0, hi = 0, hibad = 0;
    logic prev = 0;
    @(negedge clk);
    cs_n = 0; rd_n = 0;
    for (int k = 0; k < 2 * DIV * (W + 3); k++) begin
      @(negedge clk);
      if (sclk_out && !prev) begin
        bits = {bits[W-2:0], sdout};
        pulses++;
      end
      if (sclk_out) begin
        hi++;
        if (sync_out == inv_sync) syncbad++;
      end else if (prev) begin
        if (hi != DIV) hibad++;
        hi = 0;
      end
      prev = sclk_out;
    end
    chk("R5 pulse count", pulses, W);
    chk("R5 master word", bits, exp);
    chk("R5 high phase", hibad, 0);
    chk("R6 sync during transfer", syncbad, 0);
    chk("R6 sync idle after", sync_out, inv_sync);
    chk("R5 clock idle after", sclk_out, 0);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic slave_bits(input int n, output logic [W-1:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      sclk_in = inv_sclk;
      repeat (5) @(negedge clk);
      bits = {bits[W-2:0], sdout};
      sclk_in = !inv_sclk;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] got, r;
    logic t, a, b;
    int mode;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 par_out", par_out, 0);
    chk("R1 sdout", sdout, 0);
    chk("R1 sclk_out", sclk_out, 0);
    chk("R1 rd_err", rd_err, 0);
    chk("R1 sync_out", sync_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {par_out != 0, sdout, sclk_out, rd_err}, 0);

    // R2 R3 parallel, both formats
    cfg(0, 0, 0, 0);
    strobe(16'h1234, 0, 0, "R10 strobe");
    cs_n = 0; rd_n = 0; @(negedge clk);
    chk("R2 parallel offset", par_out, 16'h1234);
    cs_n = 1; rd_n = 1;
    strobe(16'h8001, 1, 0, "R10 strobe");
    cs_n = 0; rd_n = 0; @(negedge clk);
    chk("R3 two's complement", par_out, 16'h0001);
    // R4 only one of cs_n/rd_n low
    rd_n = 1; @(negedge clk);
    chk("R4 par with rd_n high", par_out, 0);
    cs_n = 1; rd_n = 0; @(negedge clk);
    chk("R4 par with cs_n high", par_out, 0);
    rd_n = 1;

    // R5 R6 master, active-low sync
    cfg(1, 0, 0, 1);
    chk("R6 idle active-low", sync_out, 1);
    strobe(16'hA5C3, 0, 0, "R10 strobe");
    master_read(16'hA5C3);

    // R7 slave, falling-edge shift
    cfg(1, 1, 1, 0);
    chk("R6 sync outside master", sync_out, 0);
    strobe(16'h7F00, 1, 0, "R10 strobe");
    cs_n = 0; rd_n = 1; @(negedge clk);
    chk("R4 sdout with rd_n high", sdout, 0);
    rd_n = 0;
    slave_bits(W, got);
    chk("R7 slave falling", got, 16'hFF00);
    cs_n = 1; rd_n = 1;
    strobe(16'h0F0F, 0, 0, "R10 done after full read");

    // R8 edges while cs_n high are ignored
    cfg(1, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      sclk_in = !sclk_in; repeat (5) @(negedge clk);
    end
    sclk_in = 1; repeat (5) @(negedge clk);
    cs_n = 0; rd_n = 0; @(negedge clk);
    chk("R8 MSB kept", sdout, 0);
    slave_bits(W, got);
    chk("R8 word intact", got, 16'h0F0F);

    // R9 partial read, then new word from MSB
    strobe(16'hC3A5, 0, 0, "R10 strobe");
    slave_bits(5, got);
    chk("R9 partial bits", got[4:0], 5'b11000);
    strobe(16'h9249, 0, 1, "R9 error pulse");
    strobe(16'h9249, 0, 0, "R10 no error on fresh word");
    slave_bits(W, got);
    chk("R9 reloaded from MSB", got, 16'h9249);
    cs_n = 1; rd_n = 1;

    // random mix
    for (int it = 0; it < 40; it++) begin
      r = W'($urandom); t = 1'($urandom); mode = $urandom % 3;
      a = 1'($urandom); b = 1'($urandom);
      cfg(mode != 0, mode == 2, a, b);
      strobe(r, t, 0, "R10 random strobe");
      if (mode == 0) begin
        cs_n = 0; rd_n = 0; @(negedge clk);
        chk("R2 random parallel", par_out, exp_fmt(r, t));
        cs_n = 1; rd_n = 1;
      end else if (mode == 1) begin
        master_read(exp_fmt(r, t));
      end else begin
        cs_n = 0; rd_n = 0;
        slave_bits(W, got);
        chk("R7 random slave", got, exp_fmt(r, t));
        cs_n = 1; rd_n = 1;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule